// File: doc/BRIEF.md
# One-Time-Programmable Array Programming Sequencer

This block drives a byte-wide one-time-programmable cell array through a full programming session. On a start command it walks the array from address zero to the last address, fires a fixed-length program strobe at high voltage, reads the byte back at high voltage, and repeats the strobe until the byte reads correctly or the attempt budget for that byte runs out. The attempt counter restarts for every new address.

Once every byte has verified, the sequencer can optionally issue a single read-protection write to a dedicated register location. It then drops to normal read voltage and compares every byte against the source data. When protection was written, every read is expected to come back as all ones. The session ends with a latched pass or fail, and on a fail it also reports the address being processed. The data to burn comes from a byte source port that always presents the byte for the current cell address.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset, busy, done, pass, fail, locked and the program strobe are all low, the high-voltage select is low, and the read/write line is high.
- R2: A start command while idle begins at address 0. Every program strobe on an array byte is driven with high-voltage select 1, register select 0 and read/write 0, with the write data equal to the source byte for that address.
- R3: Each program strobe stays high for exactly PULSE_CYC consecutive clock cycles. The cycle right after a strobe on an array byte is a verify read: high-voltage select 1, register select 0, read/write 1.
- R4: A byte that first reads back correctly after N strobes, with N no more than MAX_TRY (default 10), receives exactly N strobes. The attempt count restarts at every new address.
- R5: If a byte still mismatches after MAX_TRY strobes, the session ends with fail=1, pass=0, done=1 and fail_addr equal to that byte's address. No further strobe or compare read follows.
- R6: Array addresses receive their first strobe in strictly ascending order, 0, 1, ..., DEPTH-1, with no address skipped.
- R7: After programming, the final compare reads each address from 0 upward, one per cycle, with high-voltage select 0 and read/write 1. The first mismatch ends the session with fail=1 and fail_addr set to that address. If all DEPTH bytes match, the session ends with pass=1. pass and fail are never high together.
- R8: With lock_req=1 sampled at start, exactly one strobe is issued after the last byte verifies. That strobe uses register select 1, address PROT_ADDR (default 0xE3F), high-voltage select 1 and read/write 0. The compare then expects 0xFF at every address, and a full match sets locked=1 together with pass=1.
- R9: Results hold their values until the next start command. A start command while busy is ignored, and a start command from idle clears done, pass, fail and locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a session (accepted only while idle) |
| lock_req | input | 1 | Request the read-protection write after programming |
| src_data | input | DATA_W | Source byte for the current cell address |
| cell_addr | output | ADDR_W | Cell array address |
| cell_wdata | output | DATA_W | Data presented for programming |
| cell_pulse | output | 1 | Program strobe |
| cell_hv | output | 1 | 1 = programming voltage, 0 = normal read voltage |
| cell_regsel | output | 1 | 1 = register space, 0 = array |
| cell_rw | output | 1 | 1 = read, 0 = write |
| cell_rdata | input | DATA_W | Byte read from the cell array |
| busy | output | 1 | Session in progress |
| done | output | 1 | Session finished (held) |
| pass | output | 1 | Session passed (held) |
| fail | output | 1 | Session failed (held) |
| locked | output | 1 | Passed with read protection written (held) |
| fail_addr | output | ADDR_W | Address being processed at failure (held) |

## Verification
A fault in the attempt counter shows up at the ports within one byte. The strobe count per address changes: a counter that fails to clear starves later bytes, and a cap set wrong gives up too early or too late. A wrong address register shows up as a gap in the strobe order, or as the wrong fail_addr, by the end of the session. A wrong strobe timer shows up as a wrong strobe width on the first strobe. A wrong mode decode shows up within a cycle, because the voltage, register-select and read/write pins are checked on every strobe and on every verify and compare cycle.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_VERIFY,
        ST_PROT,
        ST_CMP
    } seq_state_e;

    typedef enum logic [2:0] {
        MD_OFF,
        MD_READ,
        MD_PROG,
        MD_VERIFY,
        MD_PROTECT
    } cell_mode_e;

    typedef struct packed {
        logic hv;
        logic regsel;
        logic rw;
    } cell_ctl_t;

    function automatic cell_ctl_t mode_to_ctl(cell_mode_e m);
        cell_ctl_t c;
        c = '{hv: 1'b0, regsel: 1'b0, rw: 1'b1};
        case (m)
            MD_READ:    c = '{hv: 1'b0, regsel: 1'b0, rw: 1'b1};
            MD_PROG:    c = '{hv: 1'b1, regsel: 1'b0, rw: 1'b0};
            MD_VERIFY:  c = '{hv: 1'b1, regsel: 1'b0, rw: 1'b1};
            MD_PROTECT: c = '{hv: 1'b1, regsel: 1'b1, rw: 1'b0};
            default:    c = '{hv: 1'b0, regsel: 1'b0, rw: 1'b1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/otp_pulse_timer.sv
module otp_pulse_timer #(
    parameter int PULSE_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic active,
    output logic fin
);
    localparam int CNT_W = $clog2(PULSE_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt_q  <= '0;
        end else if (kick) begin
            active <= 1'b1;
            cnt_q  <= CNT_W'(PULSE_CYC - 1);
        end else if (active) begin
            if (cnt_q == '0) active <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign fin = active && (cnt_q == '0);

    // R3: a new strobe is never requested while one is running
    assert_no_rekick_R3: assert property (@(posedge clk) disable iff (rst)
        kick |-> !active);

endmodule

// File: rtl/otp_retry_ctr.sv
module otp_retry_ctr #(
    parameter int MAX_TRY = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_max
);
    localparam int TRY_W = $clog2(MAX_TRY + 1);

    logic [TRY_W-1:0] tries_q;

    always_ff @(posedge clk) begin
        if (rst || clr) tries_q <= '0;
        else if (inc)   tries_q <= tries_q + 1'b1;
    end

    assign at_max = (tries_q == TRY_W'(MAX_TRY));

    // R4: the sequencer never asks for an attempt beyond the budget
    assert_retry_cap_R4: assert property (@(posedge clk) disable iff (rst)
        inc |-> (tries_q < TRY_W'(MAX_TRY)));

endmodule

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
(
    input  cell_mode_e mode,
    output logic       hv,
    output logic       regsel,
    output logic       rw
);
    cell_ctl_t ctl;

    always_comb begin
        ctl    = mode_to_ctl(mode);
        hv     = ctl.hv;
        regsel = ctl.regsel;
        rw     = ctl.rw;
    end

endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
    import otp_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter int              DATA_W    = 8,
    parameter int              DEPTH     = 32,
    parameter int              PULSE_CYC = 20,
    parameter int              MAX_TRY   = 10,
    parameter logic [11:0]     PROT_ADDR = 12'hE3F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              lock_req,
    input  logic [DATA_W-1:0] src_data,
    output logic [ADDR_W-1:0] cell_addr,
    output logic [DATA_W-1:0] cell_wdata,
    output logic              cell_pulse,
    output logic              cell_hv,
    output logic              cell_regsel,
    output logic              cell_rw,
    input  logic [DATA_W-1:0] cell_rdata,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic              locked,
    output logic [ADDR_W-1:0] fail_addr
);
    localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(DEPTH - 1);
    localparam logic [ADDR_W-1:0] PROT_A  = ADDR_W'(PROT_ADDR);

    seq_state_e        state_q, state_d;
    cell_mode_e        mode;
    logic [ADDR_W-1:0] addr_q;
    logic              lock_q;
    logic              kick, fin, r_clr, r_inc, at_max;
    logic              is_last, vfy_ok, cmp_ok;
    logic [DATA_W-1:0] cmp_exp;

    otp_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
        .clk(clk), .rst(rst), .kick(kick), .active(cell_pulse), .fin(fin)
    );

    otp_retry_ctr #(.MAX_TRY(MAX_TRY)) u_retry (
        .clk(clk), .rst(rst), .clr(r_clr), .inc(r_inc), .at_max(at_max)
    );

    otp_mode_decode u_decode (
        .mode(mode), .hv(cell_hv), .regsel(cell_regsel), .rw(cell_rw)
    );

    assign is_last = (addr_q == LAST_A);
    assign vfy_ok  = (cell_rdata == src_data);
    assign cmp_exp = lock_q ? {DATA_W{1'b1}} : src_data;
    assign cmp_ok  = (cell_rdata == cmp_exp);

    always_comb begin
        case (state_q)
            ST_PULSE:  mode = MD_PROG;
            ST_VERIFY: mode = MD_VERIFY;
            ST_PROT:   mode = MD_PROTECT;
            ST_CMP:    mode = MD_READ;
            default:   mode = MD_OFF;
        endcase
    end

    assign cell_addr  = (state_q == ST_PROT) ? PROT_A : addr_q;
    assign cell_wdata = (state_q == ST_PROT) ? '0 : src_data;
    assign busy       = (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        kick    = 1'b0;
        r_clr   = 1'b0;
        r_inc   = 1'b0;
        case (state_q)
            ST_IDLE: if (start) begin
                state_d = ST_PULSE;
                kick    = 1'b1;
                r_clr   = 1'b1;
            end
            ST_PULSE: if (fin) begin
                state_d = ST_VERIFY;
                r_inc   = 1'b1;
            end
            ST_VERIFY: begin
                if (vfy_ok) begin
                    if (!is_last) begin
                        state_d = ST_PULSE;
                        kick    = 1'b1;
                        r_clr   = 1'b1;
                    end else if (lock_q) begin
                        state_d = ST_PROT;
                        kick    = 1'b1;
                    end else begin
                        state_d = ST_CMP;
                    end
                end else if (at_max) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_PULSE;
                    kick    = 1'b1;
                end
            end
            ST_PROT: if (fin) state_d = ST_CMP;
            ST_CMP:  if (!cmp_ok || is_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            lock_q    <= 1'b0;
            done      <= 1'b0;
            pass      <= 1'b0;
            fail      <= 1'b0;
            locked    <= 1'b0;
            fail_addr <= '0;
        end else begin
            state_q <= state_d;
            case (state_q)
                ST_IDLE: if (start) begin
                    addr_q <= '0;
                    lock_q <= lock_req;
                    done   <= 1'b0;
                    pass   <= 1'b0;
                    fail   <= 1'b0;
                    locked <= 1'b0;
                end
                ST_VERIFY: begin
                    if (vfy_ok) begin
                        addr_q <= is_last ? '0 : addr_q + 1'b1;
                    end else if (at_max) begin
                        fail      <= 1'b1;
                        done      <= 1'b1;
                        fail_addr <= addr_q;
                    end
                end
                ST_CMP: begin
                    if (!cmp_ok) begin
                        fail      <= 1'b1;
                        done      <= 1'b1;
                        fail_addr <= addr_q;
                    end else if (is_last) begin
                        pass   <= 1'b1;
                        done   <= 1'b1;
                        locked <= lock_q;
                    end else begin
                        addr_q <= addr_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R2: every strobe happens at programming voltage
    assert_hv_on_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        cell_pulse |-> cell_hv);

    // R5: a failure stops all cell activity
    assert_stop_after_fail_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(fail) |-> (!cell_pulse && !busy));

    // R7: the two outcomes are exclusive
    assert_outcome_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail));

    // R8: register space is only touched at the protection location
    assert_prot_addr_R8: assert property (@(posedge clk) disable iff (rst)
        cell_regsel |-> (cell_addr == PROT_A && !cell_rw));

    // R9: results hold while idle with no start
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(fail_addr) && $stable(pass) && $stable(fail) && $stable(locked)));

endmodule

// File: tb/otp_prog_seq_tb.sv
module otp_prog_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;
    localparam int IW         = 5;
    localparam int PULSE_CYC  = 20;
    localparam int MAX_TRY    = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        lock_req = 1'b0;
    logic [7:0]  src_data;
    logic [11:0] cell_addr;
    logic [7:0]  cell_wdata, cell_rdata;
    logic        cell_pulse, cell_hv, cell_regsel, cell_rw;
    logic        busy, done, pass, fail, locked;
    logic [11:0] fail_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_prog_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .lock_req(lock_req),
        .src_data(src_data), .cell_addr(cell_addr), .cell_wdata(cell_wdata),
        .cell_pulse(cell_pulse), .cell_hv(cell_hv), .cell_regsel(cell_regsel),
        .cell_rw(cell_rw), .cell_rdata(cell_rdata), .busy(busy), .done(done),
        .pass(pass), .fail(fail), .locked(locked), .fail_addr(fail_addr)
    );

    // ---- cell array and source model ----
    logic [7:0] src_mem  [DEPTH];
    logic [7:0] cell_mem [DEPTH];
    int         need     [DEPTH];
    int         pcnt     [DEPTH];
    logic       cell_prot;
    int         corrupt_at;

    assign src_data   = src_mem[cell_addr[IW-1:0]];
    assign cell_rdata = (!cell_hv && cell_prot) ? 8'hFF : cell_mem[cell_addr[IW-1:0]];

    // ---- monitors ----
    int   total_pulses, prot_pulses, rd_cycles;
    int   bad_mode, bad_width, bad_verify, bad_order, bad_wdata, bad_prot;
    int   run_len, cur_addr;
    logic prev_pulse, prev_regsel;

    initial begin
        prev_pulse = 1'b0; prev_regsel = 1'b0; run_len = 0;
    end

    always @(negedge clk) begin
        if (cell_pulse && !prev_pulse) begin
            if (cell_regsel) begin
                prot_pulses++;
                if (!(cell_addr == 12'hE3F && cell_hv && !cell_rw)) bad_prot++;
                cell_prot = 1'b1;
            end else begin
                total_pulses++;
                if (int'(cell_addr) != cur_addr) begin
                    if (int'(cell_addr) != cur_addr + 1) bad_order++;
                    cur_addr = int'(cell_addr);
                end
                if (cell_wdata != src_mem[cell_addr[IW-1:0]]) bad_wdata++;
                pcnt[cell_addr[IW-1:0]]++;
                if (pcnt[cell_addr[IW-1:0]] >= need[cell_addr[IW-1:0]])
                    cell_mem[cell_addr[IW-1:0]] = src_mem[cell_addr[IW-1:0]];
                else
                    cell_mem[cell_addr[IW-1:0]] = src_mem[cell_addr[IW-1:0]] ^ 8'h01;
            end
        end
        if (cell_pulse && !cell_regsel && !(cell_hv && !cell_rw)) bad_mode++;
        if (cell_pulse) run_len++;
        else if (run_len != 0) begin
            if (run_len != PULSE_CYC) bad_width++;
            run_len = 0;
        end
        if (!cell_pulse && prev_pulse && !prev_regsel &&
            !(cell_hv && cell_rw && !cell_regsel)) bad_verify++;
        if (busy && !cell_hv) begin
            rd_cycles++;
            if (!cell_rw) bad_mode++;
        end
        if (busy && !cell_hv && corrupt_at >= 0) begin
            cell_mem[corrupt_at] = cell_mem[corrupt_at] ^ 8'h80;
            corrupt_at = -1;
        end
        prev_pulse  = cell_pulse;
        prev_regsel = cell_regsel;
    end

    // ---- bookkeeping ----
    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic prep(input bit lock);
        for (int i = 0; i < DEPTH; i++) begin
            src_mem[i]  = 8'((i * 37 + 5) & 8'hFF);
            cell_mem[i] = 8'h00;
            need[i]     = 1;
            pcnt[i]     = 0;
        end
        cell_prot = 1'b0; corrupt_at = -1;
        total_pulses = 0; prot_pulses = 0; rd_cycles = 0;
        bad_mode = 0; bad_width = 0; bad_verify = 0; bad_order = 0;
        bad_wdata = 0; bad_prot = 0; cur_addr = -1;
        lock_req = lock;
    endtask

    task automatic go();
        int guard;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        guard = 0;
        while (!done && guard < 20000) begin
            @(negedge clk); guard++;
        end
        check(done == 1'b1, "R9", "session finished in time", int'(done), 1);
    endtask

    task automatic t_reset();
        check(!busy && !done && !pass && !fail && !locked, "R1", "status idle after reset",
              int'({busy, done, pass, fail, locked}), 0);
        check(!cell_pulse && !cell_hv && cell_rw, "R1", "cell pins idle after reset",
              int'({cell_pulse, cell_hv, cell_rw}), 1);
    endtask

    task automatic t_basic();
        prep(1'b0);
        go();
        check(pass && !fail, "R7", "basic pass", int'({pass, fail}), 2);
        check(total_pulses == DEPTH, "R4", "one strobe per byte", total_pulses, DEPTH);
        check(bad_mode == 0 && bad_wdata == 0, "R2", "strobe mode and data", bad_mode + bad_wdata, 0);
        check(bad_width == 0, "R3", "strobe width", bad_width, 0);
        check(bad_verify == 0, "R3", "verify follows strobe", bad_verify, 0);
        check(bad_order == 0 && cur_addr == DEPTH - 1, "R6", "ascending address walk", cur_addr, DEPTH - 1);
        check(rd_cycles == DEPTH, "R7", "compare reads every byte", rd_cycles, DEPTH);
        check(!locked && prot_pulses == 0, "R8", "no protect without request", prot_pulses, 0);
    endtask

    task automatic t_retry();
        prep(1'b0);
        need[3] = MAX_TRY; need[9] = 4;
        go();
        check(pass && !fail, "R4", "retries then pass", int'({pass, fail}), 2);
        check(pcnt[3] == MAX_TRY, "R4", "byte 3 strobes at cap", pcnt[3], MAX_TRY);
        check(pcnt[9] == 4, "R4", "byte 9 strobes", pcnt[9], 4);
        check(pcnt[10] == 1, "R4", "count restarts at next address", pcnt[10], 1);
        check(bad_order == 0 && bad_width == 0, "R6", "order and width with retries", bad_order + bad_width, 0);
    endtask

    task automatic t_exhaust();
        prep(1'b0);
        need[7] = MAX_TRY + 1;
        go();
        check(fail && !pass, "R5", "exhausted byte fails", int'({pass, fail}), 1);
        check(fail_addr == 12'd7, "R5", "fail address", int'(fail_addr), 7);
        check(pcnt[7] == MAX_TRY, "R5", "strobes on failing byte", pcnt[7], MAX_TRY);
        check(pcnt[8] == 0 && rd_cycles == 0, "R5", "nothing after failure", pcnt[8] + rd_cycles, 0);
        repeat (50) @(negedge clk);
        check(fail && fail_addr == 12'd7 && done, "R9", "failure held while idle", int'(fail_addr), 7);
    endtask

    task automatic t_cmp_fail();
        prep(1'b0);
        corrupt_at = 5;
        go();
        check(fail && !pass, "R7", "compare mismatch fails", int'({pass, fail}), 1);
        check(fail_addr == 12'd5, "R7", "compare fail address", int'(fail_addr), 5);
        check(rd_cycles == 6, "R7", "compare stops at mismatch", rd_cycles, 6);
    endtask

    task automatic t_lock();
        prep(1'b1);
        go();
        check(pass && locked && !fail, "R8", "protected pass", int'({pass, locked, fail}), 6);
        check(prot_pulses == 1 && bad_prot == 0, "R8", "one protect write with right decode",
              prot_pulses * 10 + bad_prot, 10);
        check(bad_width == 0, "R3", "protect strobe width", bad_width, 0);
        check(rd_cycles == DEPTH, "R8", "compare of all-ones reads", rd_cycles, DEPTH);
    endtask

    task automatic t_restart();
        int guard;
        prep(1'b0);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy && !done && !fail && !locked, "R9", "start clears old result",
              int'({busy, done, fail, locked}), 8);
        repeat (100) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        guard = 0;
        while (!done && guard < 20000) begin
            @(negedge clk); guard++;
        end
        check(pass && total_pulses == DEPTH, "R9", "start while busy ignored", total_pulses, DEPTH);
        check(bad_order == 0, "R6", "no address restart", bad_order, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        prep(1'b0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_retry();
        t_exhaust();
        t_cmp_fail();
        t_lock();
        t_restart();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule